// File: doc/BRIEF.md
# Framed Rate-1/2 Convolutional Codec with Hard-Decision Viterbi Decoding

The block has two halves. The transmit half takes a short message of up to eight bits and runs it through a four-state convolutional code. The code has two delay stages and emits one pair of coded bits per input bit. After the message it shifts in two zero tail bits, so every frame leaves the coder in state 0. The receive half is fed the same pairs, possibly with bits flipped by a channel. For every pair it updates four path metrics with add-compare-select, using the Hamming distance between the received pair and the pair each branch would produce. It stores the four survivor decisions of that step in a frame-long buffer.

When the last pair of a frame arrives, the decoder starts from the state with the smallest path metric and walks the stored decisions backwards, one step per cycle. It places each recovered bit straight into its message position. It then raises a single-cycle done strobe and presents the message, its length and a flag. The flag tells whether the winning path needed any correction.

Top module: `viterbi_codec`

## Requirements
- R1: The coder state is {previous input, input before that}, with the newest bit on the left. For input b in state s, the emitted pair is enc_sym[1] = b^s[1]^s[0] (the first coded bit) and enc_sym[0] = b^s[0] (the second). The next state is {b, s[1]}, and each frame starts in state 0.
- R2: After a start pulse accepted while idle, message bits go out in order enc_msg[0], enc_msg[1] and so on. There is one pair per cycle, and the first pair is valid on the second clock edge after the start edge.
- R3: Each message of enc_len bits (1 to 8) is followed by two zero tail bits. The frame is exactly enc_len+2 pairs long, and enc_last is high only on the final pair.
- R4: A start pulse that arrives while a frame is still being coded is ignored, and the running frame continues unchanged.
- R5: When a frame reaches the decoder with no bit errors, dec_msg equals the original message, with unused upper bits 0. dec_len equals the number of pairs minus 2, and dec_corrected is 0.
- R6: When any single coded bit of a frame is inverted, the decoder still returns the original message and sets dec_corrected to 1.
- R7: dec_done is a one-cycle pulse that follows each frame. dec_msg, dec_len and dec_corrected hold their values until the next pulse.
- R8: Pairs presented while the decoder is tracing back, including ones marked last, are ignored. They change neither the result being produced nor the next frame.
- R9: At frame start the metric of state 0 is 0 and the other states start at a value larger than any error count a frame can reach. When two candidate paths tie, the lower-numbered predecessor is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_start | input | 1 | Start coding the message on enc_msg/enc_len |
| enc_msg | input | 8 | Message bits, bit 0 sent first |
| enc_len | input | 4 | Message length in bits (1 to 8) |
| enc_valid | output | 1 | A coded pair is present on enc_sym |
| enc_sym | output | 2 | Coded pair: bit 1 first coded bit, bit 0 second |
| enc_last | output | 1 | Final (tail) pair of the frame |
| dec_valid | input | 1 | A received pair is present on dec_sym |
| dec_sym | input | 2 | Received pair in the same bit layout as enc_sym |
| dec_last | input | 1 | Received pair is the last of its frame |
| dec_done | output | 1 | One-cycle pulse: decoded result is ready |
| dec_msg | output | 8 | Decoded message, bit 0 first |
| dec_len | output | 4 | Decoded message length |
| dec_corrected | output | 1 | Winning path metric was nonzero |

## Verification
The bench runs hand-picked messages (alternating bits, all ones, a one-bit frame) and then a stream of random messages and lengths. Each frame is sent either clean or with one flipped coded bit at a chosen or random position. Clean frames separate a correct trellis and traceback from one that merely stays at zero metric. Flips in the first pair, in the tail and in the middle of the frame show whether errors are recovered wherever they fall, and whether the correction flag follows the metric. Extra start pulses during coding and extra symbols during traceback confirm that both halves ignore input while busy.

// File: rtl/vit_pkg.sv
package vit_pkg;

    localparam int unsigned NSTATE = 4;

    typedef logic [1:0] state_t;   // {newest past input, older past input}
    typedef logic [1:0] pair_t;    // {first coded bit, second coded bit}

    typedef enum logic {
        PH_RECV  = 1'b0,
        PH_TRACE = 1'b1
    } dec_phase_t;

    function automatic pair_t code_pair(state_t s, logic b);
        return {b ^ s[1] ^ s[0], b ^ s[0]};
    endfunction

    function automatic state_t next_state(state_t s, logic b);
        return {b, s[1]};
    endfunction

    function automatic logic [1:0] pair_dist(pair_t a, pair_t b);
        pair_t x;
        x = a ^ b;
        return {1'b0, x[1]} + {1'b0, x[0]};
    endfunction

endpackage

// File: rtl/vit_encoder.sv
module vit_encoder
    import vit_pkg::*;
#(
    parameter int unsigned MSG_MAX = 8,
    parameter int unsigned STEPS   = MSG_MAX + 2,
    parameter int unsigned IW      = $clog2(STEPS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [MSG_MAX-1:0] msg,
    input  logic [IW-1:0]      len,
    output logic               out_valid,
    output pair_t              out_sym,
    output logic               out_last
);

    logic             busy;
    logic [IW-1:0]    k;
    logic [IW-1:0]    len_q;
    logic [STEPS-1:0] msg_q;
    state_t           st;
    logic             bit_in;

    assign bit_in = (k < len_q) ? msg_q[k] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            k         <= '0;
            len_q     <= '0;
            msg_q     <= '0;
            st        <= '0;
            out_valid <= 1'b0;
            out_sym   <= '0;
            out_last  <= 1'b0;
        end else if (busy) begin
            out_valid <= 1'b1;
            out_sym   <= code_pair(st, bit_in);
            st        <= next_state(st, bit_in);
            if (k == len_q + IW'(1)) begin
                out_last <= 1'b1;
                busy     <= 1'b0;
            end else begin
                out_last <= 1'b0;
                k        <= k + IW'(1);
            end
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            if (start) begin
                busy  <= 1'b1;
                k     <= '0;
                st    <= '0;
                len_q <= len;
                msg_q <= STEPS'(msg);
            end
        end
    end

    // R3: two zero tail bits bring the coder back to state 0 on the last pair
    a_r3_tail_zero: assert property (@(posedge clk) disable iff (rst)
        out_last |-> (st == 2'b00));

    // R3: the last flag only ever accompanies a valid pair
    a_r3_last_valid: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R4: a start pulse during coding leaves the latched message alone
    a_r4_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(msg_q) && $stable(len_q));

    // R2: a pair appears on the edge after the coder becomes busy
    a_r2_first_pair: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> out_valid);

endmodule

// File: rtl/vit_acs.sv
module vit_acs
    import vit_pkg::*;
#(
    parameter int unsigned PMW = 6
) (
    input  logic [PMW-1:0] pm_lo,
    input  logic [PMW-1:0] pm_hi,
    input  pair_t          exp_lo,
    input  pair_t          exp_hi,
    input  pair_t          rx,
    output logic [PMW-1:0] pm_out,
    output logic           pick_hi
);

    logic [PMW-1:0] cand_lo;
    logic [PMW-1:0] cand_hi;

    always_comb begin
        cand_lo = pm_lo + PMW'(pair_dist(rx, exp_lo));
        cand_hi = pm_hi + PMW'(pair_dist(rx, exp_hi));
        pick_hi = (cand_hi < cand_lo);          // tie keeps lower predecessor
        pm_out  = pick_hi ? cand_hi : cand_lo;
    end

endmodule

// File: rtl/vit_decoder.sv
module vit_decoder
    import vit_pkg::*;
#(
    parameter int unsigned MSG_MAX = 8,
    parameter int unsigned STEPS   = MSG_MAX + 2,
    parameter int unsigned IW      = $clog2(STEPS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  pair_t              in_sym,
    input  logic               in_last,
    output logic               done,
    output logic [MSG_MAX-1:0] msg_out,
    output logic [IW-1:0]      len_out,
    output logic               corrected
);

    localparam int unsigned BIG = 2 * STEPS + 1;
    localparam int unsigned PMW = $clog2(BIG + 2 * STEPS + 1);
    localparam logic [NSTATE-1:0][PMW-1:0] PM_INIT =
        {PMW'(BIG), PMW'(BIG), PMW'(BIG), PMW'(0)};

    dec_phase_t                    phase;
    logic [NSTATE-1:0][PMW-1:0]    pm;
    logic [NSTATE-1:0][PMW-1:0]    pm_nxt;
    logic [NSTATE-1:0]             pick;
    logic [STEPS-1:0][NSTATE-1:0]  surv;
    logic [IW-1:0]                 step;
    logic [IW-1:0]                 tb_idx;
    state_t                        tb_state;
    logic [IW-1:0]                 nmsg;
    logic [PMW-1:0]                fin_metric;
    logic [STEPS-1:0]              acc;
    logic [STEPS-1:0]              acc_nxt;
    logic [MSG_MAX-1:0]            msg_mask;
    state_t                        best_s;
    logic [PMW-1:0]                best_m;

    for (genvar s = 0; s < NSTATE; s++) begin : g_acs
        localparam logic [1:0] SV  = 2'(s);
        localparam state_t     PLO = {SV[0], 1'b0};
        localparam state_t     PHI = {SV[0], 1'b1};
        vit_acs #(.PMW(PMW)) u_acs (
            .pm_lo   (pm[PLO]),
            .pm_hi   (pm[PHI]),
            .exp_lo  (code_pair(PLO, SV[1])),
            .exp_hi  (code_pair(PHI, SV[1])),
            .rx      (in_sym),
            .pm_out  (pm_nxt[s]),
            .pick_hi (pick[s])
        );
    end

    always_comb begin
        best_s = '0;
        best_m = pm_nxt[0];
        for (int i = 1; i < NSTATE; i++) begin
            if (pm_nxt[i] < best_m) begin
                best_m = pm_nxt[i];
                best_s = state_t'(i);
            end
        end
    end

    always_comb begin
        for (int i = 0; i < STEPS; i++)
            acc_nxt[i] = (IW'(i) == tb_idx) ? tb_state[1] : acc[i];
        for (int i = 0; i < MSG_MAX; i++)
            msg_mask[i] = acc_nxt[i] & (IW'(i) < nmsg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_RECV;
            pm         <= PM_INIT;
            surv       <= '0;
            step       <= '0;
            tb_idx     <= '0;
            tb_state   <= '0;
            nmsg       <= '0;
            fin_metric <= '0;
            acc        <= '0;
            done       <= 1'b0;
            msg_out    <= '0;
            len_out    <= '0;
            corrected  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_RECV: begin
                    if (in_valid) begin
                        surv[step] <= pick;
                        if (in_last) begin
                            pm         <= PM_INIT;
                            step       <= '0;
                            phase      <= PH_TRACE;
                            tb_idx     <= step;
                            tb_state   <= best_s;
                            fin_metric <= best_m;
                            nmsg       <= (step != '0) ? step - IW'(1) : '0;
                            acc        <= '0;
                        end else begin
                            pm <= pm_nxt;
                            if (step != IW'(STEPS - 1))
                                step <= step + IW'(1);
                        end
                    end
                end
                PH_TRACE: begin
                    acc      <= acc_nxt;
                    tb_state <= {tb_state[0], surv[tb_idx][tb_state]};
                    if (tb_idx == '0) begin
                        phase     <= PH_RECV;
                        done      <= 1'b1;
                        msg_out   <= msg_mask;
                        len_out   <= nmsg;
                        corrected <= (fin_metric != '0);
                    end else begin
                        tb_idx <= tb_idx - IW'(1);
                    end
                end
                default: phase <= PH_RECV;
            endcase
        end
    end

    // R7: done never lasts two cycles
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: metrics do not move while tracing back
    a_r8_pm_frozen: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TRACE) |=> $stable(pm));

    // R9: a new frame always begins from the initial metric set
    a_r9_pm_init: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TRACE) |-> (pm == PM_INIT));

    // R5: reported length never exceeds the message capacity
    a_r5_len_range: assert property (@(posedge clk) disable iff (rst)
        done |-> (len_out <= IW'(MSG_MAX)));

endmodule

// File: rtl/viterbi_codec.sv
module viterbi_codec
    import vit_pkg::*;
#(
    parameter int unsigned MSG_MAX = 8,
    localparam int unsigned STEPS  = MSG_MAX + 2,
    localparam int unsigned IW     = $clog2(STEPS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enc_start,
    input  logic [MSG_MAX-1:0] enc_msg,
    input  logic [IW-1:0]      enc_len,
    output logic               enc_valid,
    output logic [1:0]         enc_sym,
    output logic               enc_last,
    input  logic               dec_valid,
    input  logic [1:0]         dec_sym,
    input  logic               dec_last,
    output logic               dec_done,
    output logic [MSG_MAX-1:0] dec_msg,
    output logic [IW-1:0]      dec_len,
    output logic               dec_corrected
);

    vit_encoder #(.MSG_MAX(MSG_MAX), .STEPS(STEPS), .IW(IW)) u_enc (
        .clk       (clk),
        .rst       (rst),
        .start     (enc_start),
        .msg       (enc_msg),
        .len       (enc_len),
        .out_valid (enc_valid),
        .out_sym   (enc_sym),
        .out_last  (enc_last)
    );

    vit_decoder #(.MSG_MAX(MSG_MAX), .STEPS(STEPS), .IW(IW)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (dec_valid),
        .in_sym    (dec_sym),
        .in_last   (dec_last),
        .done      (dec_done),
        .msg_out   (dec_msg),
        .len_out   (dec_len),
        .corrected (dec_corrected)
    );

endmodule

// File: tb/tb_viterbi_codec.sv
module tb_viterbi_codec;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enc_start = 1'b0;
    logic [7:0] enc_msg = '0;
    logic [3:0] enc_len = '0;
    logic       enc_valid;
    logic [1:0] enc_sym;
    logic       enc_last;
    logic       dec_valid = 1'b0;
    logic [1:0] dec_sym = '0;
    logic       dec_last = 1'b0;
    logic       dec_done;
    logic [7:0] dec_msg;
    logic [3:0] dec_len;
    logic       dec_corrected;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic [7:0] q_msg[$];
    logic [3:0] q_len[$];
    logic       q_cor[$];
    logic       done_prev = 1'b0;

    always #5 clk = ~clk;

    viterbi_codec dut (
        .clk(clk), .rst(rst),
        .enc_start(enc_start), .enc_msg(enc_msg), .enc_len(enc_len),
        .enc_valid(enc_valid), .enc_sym(enc_sym), .enc_last(enc_last),
        .dec_valid(dec_valid), .dec_sym(dec_sym), .dec_last(dec_last),
        .dec_done(dec_done), .dec_msg(dec_msg), .dec_len(dec_len),
        .dec_corrected(dec_corrected)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected results as the decoder produces them
    always @(negedge clk) begin
        if (!rst) begin
            if (done_prev)
                check(!dec_done, "R7 done single pulse", dec_done, 0);
            if (dec_done) begin
                if (q_msg.size() == 0) begin
                    check(1'b0, "R7 unexpected done", 1, 0);
                end else begin
                    logic [7:0] em;
                    logic [3:0] el;
                    logic       ec;
                    em = q_msg.pop_front();
                    el = q_len.pop_front();
                    ec = q_cor.pop_front();
                    check(dec_msg == em, ec ? "R6 message" : "R5 message", dec_msg, em);
                    check(dec_len == el, "R5 length", dec_len, el);
                    check(dec_corrected == ec, ec ? "R6 corrected flag" : "R5 corrected flag",
                          dec_corrected, ec);
                end
            end
            done_prev <= dec_done;
        end
    end

    // driver: codes a frame, checks the pairs, feeds the decoder
    task automatic run_frame(input logic [7:0] m, input int len, input int errpos,
                             input bit poke_start, input bit poke_trace);
        logic [1:0] syms[16];
        logic [1:0] st;
        logic [7:0] mm;
        int  n, got, bad, lastbad;
        n = len + 2;
        mm = '0;
        for (int i = 0; i < len; i++) mm[i] = m[i];
        q_msg.push_back(mm);
        q_len.push_back(4'(len));
        q_cor.push_back(errpos >= 0);

        @(negedge clk);
        enc_start = 1'b1; enc_msg = m; enc_len = 4'(len);
        got = 0; bad = 0; lastbad = 0; st = 2'b00;
        for (int c = 0; c < 40 && got < n; c++) begin
            @(negedge clk);
            if (poke_start && c == 1) begin
                enc_start = 1'b1; enc_msg = ~m; enc_len = 4'd8;
            end else begin
                enc_start = 1'b0;
            end
            if (c == 0) check(!enc_valid, "R2 no pair before second edge", enc_valid, 0);
            if (enc_valid) begin
                logic b;
                logic [1:0] e;
                b = (got < len) ? m[got] : 1'b0;
                e = {b ^ st[1] ^ st[0], b ^ st[0]};
                st = {b, st[1]};
                if (enc_sym !== e) bad++;
                if (enc_last !== (got == n - 1)) lastbad++;
                syms[got] = enc_sym;
                got++;
            end
        end
        enc_start = 1'b0;
        check(bad == 0, poke_start ? "R4 pairs unchanged by extra start" : "R1 R2 coded pairs",
              bad, 0);
        check(got == n && lastbad == 0, "R3 frame length and last flag", got, n);
        @(negedge clk);
        check(!enc_valid, "R3 frame ends", enc_valid, 0);

        if (errpos >= 0)
            syms[errpos / 2] ^= (errpos % 2 == 0) ? 2'b10 : 2'b01;
        for (int i = 0; i < n; i++) begin
            dec_valid = 1'b1; dec_sym = syms[i]; dec_last = (i == n - 1);
            @(negedge clk);
        end
        if (poke_trace) begin
            for (int i = 0; i < 2; i++) begin   // R8 stray pairs during traceback
                dec_valid = 1'b1; dec_sym = 2'($urandom); dec_last = 1'b1;
                @(negedge clk);
            end
        end
        dec_valid = 1'b0; dec_last = 1'b0;
        for (int g = 0; g < 60 && q_msg.size() > 0; g++) @(negedge clk);
        check(q_msg.size() == 0, "R7 result produced", q_msg.size(), 0);
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!enc_valid && !dec_done && dec_msg == 0, "R7 reset state", dec_msg, 0);

        run_frame(8'hA5, 8, -1, 1'b0, 1'b0);            // R5 clean frame
        run_frame(8'hFF, 8, -1, 1'b0, 1'b0);            // R5 all ones
        run_frame(8'h01, 1, -1, 1'b0, 1'b0);            // R3 shortest frame
        run_frame(8'h3C, 8, 0, 1'b0, 1'b0);             // R6 error in first bit
        run_frame(8'h3C, 8, 19, 1'b0, 1'b0);            // R6 error in final tail bit
        run_frame(8'h96, 5, 7, 1'b0, 1'b0);             // R6 mid-frame error
        run_frame(8'h5A, 8, -1, 1'b1, 1'b0);            // R4 start while busy
        run_frame(8'hC3, 6, 4, 1'b0, 1'b1);             // R8 stray pairs in traceback
        run_frame(8'h00, 3, -1, 1'b0, 1'b0);            // R8 next frame unaffected; R9 zero path
        for (int t = 0; t < 40; t++) begin
            int len, ep;
            len = 1 + int'($urandom_range(0, 7));
            ep  = ($urandom_range(0, 1) == 0) ? -1 : int'($urandom_range(0, 2 * (len + 2) - 1));
            run_frame(8'($urandom), len, ep, t % 7 == 3, t % 5 == 2);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule